// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the two clocks of an audio serial port from a single master clock: a frame clock that runs at the sample rate and a bit clock that runs at exactly 64 times that rate. A two-bit speed selection and an optional halving of the master clock set the division ratios. In single speed the frame clock is the master clock divided by 256, in double speed by 128 and in quad speed by 64. The bit clock divisor is 4, 2 or 1 in the same modes. Across the supported output range of 2 kHz to 204 kHz, each speed covers its own band of rates: roughly 2 to 51 kHz, 50 to 102 kHz and 100 to 204 kHz.

Everything runs synchronously in the master clock domain. The frame and bit clocks leave the block as registered waveforms. Each also has a one-cycle enable pulse, so that logic downstream can work on the master clock and need not be clocked by a derived one. A new setting is held back until the current frame ends, so a frame is never cut short. The reserved speed code stops both clocks and raises a flag.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_ni` is low, `lrck_o`, `sclk_o`, `bit_en_o`, `frame_en_o` and `rsvd_o` are all low.
- R2: Speed code 00 is single, 01 is double and 10 is quad. The frame period is 256, 128 or 64 master cycles respectively. It is doubled when `prediv_i` is 1.
- R3: When a bit period P (in master cycles) is 2 or more, it is one sixty-fourth of the frame. `sclk_o` is low for the first P/2 cycles of each bit period and high for the rest, so every bit begins on a falling edge of the bit clock.
- R4: In quad speed with `prediv_i` at 0, the bit period is one master cycle. `sclk_o` then stays high and `bit_en_o` is asserted on every cycle of the frame.
- R5: `lrck_o` is low for bits 0 to 31 of a frame and high for bits 32 to 63. It changes only in the first cycle of a bit period.
- R6: `bit_en_o` pulses in the first cycle of each bit period. `frame_en_o` pulses in the first cycle of each frame, together with `bit_en_o`, and there are exactly 64 bit pulses per frame.
- R7: A change of `speed_i` or `prediv_i` during a frame leaves that frame's waveforms unchanged. The new setting governs the frames that follow.
- R8: Selecting code 11 stops the clocks at the next frame boundary: from then on `rsvd_o` is high and every other output is low. When a valid code is applied, `frame_en_o` rises and `rsvd_o` falls on the second master clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 2 | Speed selection (00 single, 01 double, 10 quad, 11 reserved) |
| prediv_i | input | 1 | Halve the master clock before the dividers |
| lrck_o | output | 1 | Frame clock waveform, low in the first half of the frame |
| sclk_o | output | 1 | Bit clock waveform |
| bit_en_o | output | 1 | One-cycle pulse at the start of each bit period |
| frame_en_o | output | 1 | One-cycle pulse at the start of each frame |
| rsvd_o | output | 1 | Reserved speed selection is in effect |

## Verification
The checker watches every cycle for the local rules:
- the frame clock moves only at a bit boundary;
- a falling bit-clock edge lines up with a bit pulse;
- a frame pulse always coincides with a bit pulse;
- 64 bit pulses fall between two frame pulses;
- the outputs are quiet in the reserved state;
- the active setting never changes inside a frame.

The bench sweeps all six valid settings and compares every output, cycle by cycle, against values computed from the frame position. This covers the exact divisor in each mode, the 50% frame duty and the always-high bit clock of the fastest setting. Only these scenarios show that a setting changed in the middle of a frame leaves that frame intact. They also show the exact latency when leaving the reserved state.

// File: rtl/acg_pkg.sv
package acg_pkg;

  // Bits in one frame, and the largest log2 of a bit period in master cycles.
  localparam int unsigned BITS_PER_FRAME = 64;
  localparam int unsigned MAX_SHIFT      = 3;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  typedef struct packed {
    speed_e speed;
    logic   prediv;
  } cfg_t;

  // log2 of the bit period in master cycles: the mode's base shift plus one when prescaled.
  function automatic logic [1:0] bit_shift(cfg_t c);
    logic [1:0] base;
    case (c.speed)
      SPD_SINGLE: base = 2'd2;
      SPD_DOUBLE: base = 2'd1;
      default:    base = 2'd0;
    endcase
    return base + {1'b0, c.prediv};
  endfunction

endpackage

// File: rtl/acg_cfg_ctl.sv
module acg_cfg_ctl
  import acg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_in_i,
  input  logic frame_last_i,
  output cfg_t cfg_o,
  output logic run_o,
  output logic load_o
);

  // A setting is taken only while idle or on the final cycle of a frame.
  assign load_o = !run_o || frame_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '{speed: SPD_SINGLE, prediv: 1'b0};
      run_o <= 1'b0;
    end else if (load_o) begin
      cfg_o <= cfg_in_i;
      run_o <= (cfg_in_i.speed != SPD_RSVD);
    end
  end

endmodule

// File: rtl/acg_phase_ctr.sv
module acg_phase_ctr #(
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned CNT_W          = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [1:0]       shift_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W:0] span;

  // One bit wider than the counter, so that the longest frame length still fits.
  assign span   = (CNT_W+1)'(BITS_PER_FRAME) << shift_i;
  assign last_o = run_i && ({1'b0, cnt_o} == (span - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= '0;
    end else if (run_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/acg_wave.sv
module acg_wave #(
  parameter int unsigned BIT_IDX_W = 6,
  parameter int unsigned CNT_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rsvd_i,
  input  logic [1:0]       shift_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             lrck_o,
  output logic             sclk_o,
  output logic             bit_en_o,
  output logic             frame_en_o,
  output logic             rsvd_o
);

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] bit_idx;
  logic             lrck_n, sclk_n, bit_n, frame_n;

  always_comb begin
    mask    = (CNT_W'(1) << shift_i) - 1'b1;
    phase   = cnt_i & mask;
    bit_idx = cnt_i >> shift_i;
    // The frame clock is the top bit of the bit index: low in the first half, high in the second.
    lrck_n  = run_i && bit_idx[BIT_IDX_W-1];
    // A one-cycle bit period keeps the bit clock high; longer ones are low, then high.
    sclk_n  = run_i && ((shift_i == 2'd0) || (phase > (mask >> 1)));
    bit_n   = run_i && (phase == '0);
    frame_n = run_i && (cnt_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_o     <= 1'b0;
      sclk_o     <= 1'b0;
      bit_en_o   <= 1'b0;
      frame_en_o <= 1'b0;
      rsvd_o     <= 1'b0;
    end else begin
      lrck_o     <= lrck_n;
      sclk_o     <= sclk_n;
      bit_en_o   <= bit_n;
      frame_en_o <= frame_n;
      rsvd_o     <= rsvd_i;
    end
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] speed_i,
  input  logic       prediv_i,
  output logic       lrck_o,
  output logic       sclk_o,
  output logic       bit_en_o,
  output logic       frame_en_o,
  output logic       rsvd_o
);

  localparam int unsigned BIT_IDX_W = $clog2(BITS_PER_FRAME);
  localparam int unsigned CNT_W     = BIT_IDX_W + MAX_SHIFT;

  cfg_t             cfg_in;
  cfg_t             cfg_q;
  logic             run_q;
  logic             load;
  logic             last;
  logic [1:0]       shift;
  logic [CNT_W-1:0] cnt;
  logic             idle_rsvd;

  assign cfg_in    = '{speed: speed_e'(speed_i), prediv: prediv_i};
  assign shift     = bit_shift(cfg_q);
  assign idle_rsvd = !run_q && (cfg_q.speed == SPD_RSVD);

  acg_cfg_ctl u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_in_i     (cfg_in),
    .frame_last_i (last),
    .cfg_o        (cfg_q),
    .run_o        (run_q),
    .load_o       (load)
  );

  acg_phase_ctr #(
    .BITS_PER_FRAME (BITS_PER_FRAME),
    .CNT_W          (CNT_W)
  ) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .load_i  (load),
    .shift_i (shift),
    .cnt_o   (cnt),
    .last_o  (last)
  );

  acg_wave #(
    .BIT_IDX_W (BIT_IDX_W),
    .CNT_W     (CNT_W)
  ) u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .rsvd_i     (idle_rsvd),
    .shift_i    (shift),
    .cnt_i      (cnt),
    .lrck_o     (lrck_o),
    .sclk_o     (sclk_o),
    .bit_en_o   (bit_en_o),
    .frame_en_o (frame_en_o),
    .rsvd_o     (rsvd_o)
  );

endmodule

// File: rtl/acg_checker.sv
module acg_checker
  import acg_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic lrck_o,
  input logic sclk_o,
  input logic bit_en_o,
  input logic frame_en_o,
  input logic rsvd_o,
  input logic load_i,
  input cfg_t cfg_i
);

  logic [7:0] bits_q;
  logic       seen_q;

  // Counts bit pulses since the last frame pulse; that pulse itself counts as one.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      seen_q <= 1'b0;
    end else if (frame_en_o) begin
      bits_q <= 8'd1;
      seen_q <= 1'b1;
    end else if (bit_en_o) begin
      bits_q <= bits_q + 8'd1;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!lrck_o && !sclk_o && !bit_en_o && !frame_en_o && !rsvd_o));

  p_sclk_fall_on_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (bit_en_o || rsvd_o));

  p_lrck_on_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_o != $past(lrck_o)) |-> (bit_en_o || rsvd_o));

  p_frame_on_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_en_o |-> (bit_en_o && !lrck_o));

  p_bits_per_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_en_o && seen_q) |-> (bits_q == 8'd64));

  p_cfg_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_i));

  p_reserved_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> (!lrck_o && !sclk_o && !bit_en_o && !frame_en_o));

endmodule

bind audio_clkgen acg_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lrck_o     (lrck_o),
  .sclk_o     (sclk_o),
  .bit_en_o   (bit_en_o),
  .frame_en_o (frame_en_o),
  .rsvd_o     (rsvd_o),
  .load_i     (load),
  .cfg_i      (cfg_q)
);

// File: tb/tb_audio_clkgen.sv
`timescale 1ns/1ps
module tb_audio_clkgen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] speed_i = 2'b00;
  logic       prediv_i = 1'b0;
  logic       lrck_o, sclk_o, bit_en_o, frame_en_o, rsvd_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk_i = ~clk_i;

  audio_clkgen dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed_i    (speed_i),
    .prediv_i   (prediv_i),
    .lrck_o     (lrck_o),
    .sclk_o     (sclk_o),
    .bit_en_o   (bit_en_o),
    .frame_en_o (frame_en_o),
    .rsvd_o     (rsvd_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frame(output bit found);
    int t = 0;
    while (!frame_en_o && t < 2000) begin
      @(negedge clk_i);
      t++;
    end
    found = frame_en_o;
  endtask

  // Measures one frame for setting (mode, pre) and applies the next setting at position 5.
  task automatic measure(input int mode, input int pre, input int nmode, input int npre);
    bit found;
    int k, p, f, e_lr, e_sc, e_en, e_rs;
    k = pre + 2 - mode;
    p = 1 << k;
    f = 64 * p;
    e_lr = 0; e_sc = 0; e_en = 0; e_rs = 0;
    wait_frame(found);
    check(found, "R2 frame start", int'(found), 1);
    for (int i = 0; i < f; i++) begin
      bit x_lr, x_sc, x_bit, x_frm;
      x_lr  = ((i >> k) >= 32);
      x_sc  = (k == 0) ? 1'b1 : ((i % p) >= (p / 2));
      x_bit = ((i % p) == 0);
      x_frm = (i == 0);
      if (lrck_o !== x_lr) e_lr++;
      if (sclk_o !== x_sc) e_sc++;
      if (bit_en_o !== x_bit || frame_en_o !== x_frm) e_en++;
      if (rsvd_o !== 1'b0) e_rs++;
      if (i == 5) begin
        speed_i  = 2'(nmode);
        prediv_i = 1'(npre);
      end
      @(negedge clk_i);
    end
    check(e_lr == 0, "R5 frame clock pattern", e_lr, 0);
    if (k == 0) check(e_sc == 0, "R4 bit clock steady high", e_sc, 0);
    else        check(e_sc == 0, "R3 bit clock pattern", e_sc, 0);
    check(e_en == 0, "R6 enable pulses", e_en, 0);
    check(e_rs == 0 && (e_lr + e_sc + e_en) == 0, "R7 frame kept after mid-frame change", e_rs, 0);
    if (nmode != 3) check(frame_en_o === 1'b1, "R2 frame length", int'(frame_en_o), 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    int quiet_err;
    repeat (5) @(negedge clk_i);
    check({lrck_o, sclk_o, bit_en_o, frame_en_o, rsvd_o} == 5'b0, "R1 reset outputs",
          int'({lrck_o, sclk_o, bit_en_o, frame_en_o, rsvd_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // Sweep all six valid settings; each measured frame arms the next setting.
    for (int j = 0; j < 6; j++) begin
      int nm, np;
      nm = (j == 5) ? 3 : ((j + 1) >> 1);
      np = (j == 5) ? 0 : ((j + 1) & 1);
      measure(j >> 1, j & 1, nm, np);
    end
    // Reserved code takes hold at the boundary that just passed.
    quiet_err = 0;
    for (int i = 0; i < 50; i++) begin
      if (rsvd_o !== 1'b1 || lrck_o || sclk_o || bit_en_o || frame_en_o) quiet_err++;
      @(negedge clk_i);
    end
    check(quiet_err == 0, "R8 reserved outputs quiet", quiet_err, 0);
    speed_i  = 2'b00;
    prediv_i = 1'b0;
    @(negedge clk_i);
    check(rsvd_o === 1'b1 && frame_en_o === 1'b0, "R8 one edge after leaving reserved",
          int'(rsvd_o), 1);
    @(negedge clk_i);
    check(frame_en_o === 1'b1 && rsvd_o === 1'b0, "R8 restart on second edge",
          int'(frame_en_o), 1);
    measure(0, 0, 2, 1);
    measure(2, 1, 2, 1);
    // Reset in the middle of a frame.
    repeat (37) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check({lrck_o, sclk_o, bit_en_o, frame_en_o, rsvd_o} == 5'b0, "R1 mid-run reset",
          int'({lrck_o, sclk_o, bit_en_o, frame_en_o, rsvd_o}), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule